// File: doc/BRIEF.md
# Sliding-Window Address Sequencer

This block produces a one-dimensional stream of memory addresses for a data-stream engine, without any instruction fetch. Within one sweep, the address walks from a floor toward a ceiling by a fixed increment. When a sweep ends, the floor and the ceiling each move by their own signed offset and the next sweep starts from the new floor. The window therefore slides across memory, sweep after sweep, until a programmed number of sweeps has been emitted.

The address, the floor and the ceiling are each held by an instance of the same stepping register. A small controller counts addresses within the sweep and counts sweeps. A one-cycle start pulse loads the starting floor and ceiling and begins a new run. A hold input freezes the whole block. The configuration inputs must stay steady while a run is in progress.

Top module: `slide_addr_gen`

## Requirements
- R1: After reset, `addr_o` is 0 and both `valid_o` and `done_o` are 0.
- R2: In the cycle after `start_i` is sampled high, `valid_o` is 1, `addr_o` equals `floor_init_i`, and `done_o` is 0. `start_i` takes priority over `hold_i`.
- R3: While the floor is at or below the ceiling, each emitted address is the previous address plus `stride_i`. `valid_o` is high for exactly one cycle per address.
- R4: While the floor is above the ceiling, each emitted address is the previous address minus `stride_i`.
- R5: An address that lands exactly on the ceiling is emitted, and it is the last address of its sweep.
- R6: A sweep ends on the last address whose next step would pass the ceiling. No address outside the window between floor and ceiling is ever emitted.
- R7: A sweep ends after `max_steps_i` addresses even if the ceiling has not been reached. A value of 0 acts as 1.
- R8: After a sweep that is not the final one, the floor moves by `floor_step_i` and the ceiling by `ceil_step_i`. Both are two's-complement and wrap modulo 2^16. The next sweep then starts at the new floor on the following cycle.
- R9: When `sweeps_i` sweeps have finished (0 acts as 1), `done_o` rises in the cycle after the final address. It stays high with `valid_o` low until the next `start_i`.
- R10: While `hold_i` is high, `valid_o` is 0 and no state changes. When it is released, the sequence resumes exactly where it stopped.
- R11: A `start_i` pulse in the middle of a run abandons that run. The new sequence begins from the current configuration.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | Load initial floor and ceiling, begin a run |
| hold_i | input | 1 | Freeze all state, suppress valid |
| floor_init_i | input | 16 | Starting floor; first address of the run |
| ceil_init_i | input | 16 | Starting ceiling |
| stride_i | input | 16 | Address increment magnitude within a sweep |
| floor_step_i | input | 16 | Signed floor offset applied between sweeps |
| ceil_step_i | input | 16 | Signed ceiling offset applied between sweeps |
| max_steps_i | input | 16 | Address count cap per sweep (0 acts as 1) |
| sweeps_i | input | 16 | Number of sweeps in the run (0 acts as 1) |
| addr_o | output | 16 | Current address |
| valid_o | output | 1 | Address on `addr_o` is emitted this cycle |
| done_o | output | 1 | Run complete |

## Verification
The bench targets five behaviours. The first is the ceiling landed on exactly versus a stride that would overshoot it; a design with a strict compare or a post-step test would drop the ceiling or emit an address outside the window. The second is descending windows and negative slider offsets; a wrong direction choice or a missing sign extension would walk away from the ceiling or slide the window the wrong way. The third is the per-sweep count cap and the zero values of both counts; an off-by-one there would emit one address too many or too few, or hang on zero. The fourth is a hold in mid-sweep, which shows whether the sequence loses or repeats an address. The fifth is a restart in mid-run, which shows whether old counters leak into the new sequence.

// File: rtl/slide_pkg.sv
// Shared types for the sliding-window address sequencer.
// Assumes nothing beyond a standard SystemVerilog package scope.
package slide_pkg;

    // Run state of the sequence controller.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } seq_state_e;

endpackage

// File: rtl/slide_stepper.sv
// Basic stepping register: one instance holds the address, one the floor,
// one the ceiling. A load overrides an advance; an advance adds a
// two's-complement delta (wrapping). Assumes load and advance come from
// the controller, already qualified by hold and start.
module slide_stepper #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         load_i,
    input  logic [W-1:0] load_val_i,
    input  logic         adv_i,
    input  logic [W-1:0] delta_i,
    output logic [W-1:0] value_o
);

    logic [W-1:0] value_q;

    // Hold, load or step the stored value.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value_q <= '0;
        end else if (load_i) begin
            value_q <= load_val_i;
        end else if (adv_i) begin
            value_q <= value_q + delta_i;
        end
    end

    assign value_o = value_q;

    // Without load or advance the value must not move (R10 freeze relies on it).
    p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !adv_i) |=> $stable(value_o));

endmodule

// File: rtl/slide_end_detect.sv
// Combinational sweep-end test. Picks the walking direction from the
// current floor and ceiling, and flags the current address as the last
// one of its sweep when it sits on or past the ceiling, or when one more
// stride would pass it. Uses differences rather than sums, so a stride
// near the top of the range cannot wrap.
module slide_end_detect #(
    parameter int W = 16
) (
    input  logic [W-1:0] addr_i,
    input  logic [W-1:0] floor_i,
    input  logic [W-1:0] ceil_i,
    input  logic [W-1:0] stride_i,
    output logic         up_o,
    output logic         hit_o
);

    logic         up;
    logic [W-1:0] gap;
    logic         at_bound;

    // Direction and the remaining distance to the ceiling.
    always_comb begin
        up       = (floor_i <= ceil_i);
        at_bound = up ? (addr_i >= ceil_i) : (addr_i <= ceil_i);
        gap      = up ? (ceil_i - addr_i) : (addr_i - ceil_i);
    end

    assign up_o  = up;
    assign hit_o = at_bound || (gap < stride_i);

endmodule

// File: rtl/slide_seq_ctrl.sv
// Sequence controller: run state, address count inside the sweep, and
// sweep count. Emits one address per cycle while running and not held.
// Decides sweep end (ceiling hit or count cap) and run end (last sweep).
// Assumes max_steps_i and sweeps_i stay steady during a run.
module slide_seq_ctrl
    import slide_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          hold_i,
    input  logic          hit_i,
    input  logic [CW-1:0] max_steps_i,
    input  logic [CW-1:0] sweeps_i,
    output logic          emit_o,
    output logic          sweep_end_o,
    output logic          finish_o,
    output logic          done_o
);

    seq_state_e    state_q;
    logic [CW-1:0] step_cnt_q;
    logic [CW-1:0] sweep_cnt_q;
    logic [CW:0]   step_nx;
    logic [CW:0]   sweep_nx;
    logic          emit;
    logic          cap_reached;
    logic          sweep_end;
    logic          last_sweep;

    // Emit, sweep-end and run-end decisions for the current cycle.
    always_comb begin
        step_nx     = {1'b0, step_cnt_q} + 1'b1;
        sweep_nx    = {1'b0, sweep_cnt_q} + 1'b1;
        emit        = (state_q == ST_RUN) && !hold_i && !start_i;
        cap_reached = (step_nx >= {1'b0, max_steps_i});
        last_sweep  = (sweep_nx >= {1'b0, sweeps_i});
        sweep_end   = emit && (hit_i || cap_reached);
    end

    // Run state and both counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            step_cnt_q  <= '0;
            sweep_cnt_q <= '0;
        end else if (start_i) begin
            state_q     <= ST_RUN;
            step_cnt_q  <= '0;
            sweep_cnt_q <= '0;
        end else if (emit) begin
            if (sweep_end) begin
                step_cnt_q <= '0;
                if (last_sweep) begin
                    state_q <= ST_DONE;
                end else begin
                    sweep_cnt_q <= sweep_cnt_q + 1'b1;
                end
            end else begin
                step_cnt_q <= step_cnt_q + 1'b1;
            end
        end
    end

    assign emit_o      = emit;
    assign sweep_end_o = sweep_end;
    assign finish_o    = sweep_end && last_sweep;
    assign done_o      = (state_q == ST_DONE);

    // The address count inside a sweep never reaches the cap.
    p_step_cap_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && max_steps_i != '0) |-> (step_cnt_q < max_steps_i));

    // Completion is held until a new start.
    p_done_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> done_o);

    // The final sweep end leads to completion on the next cycle.
    p_finish_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (finish_o && !start_i) |=> done_o);

endmodule

// File: rtl/slide_addr_gen.sv
// Sliding-window address sequencer top. Three identical stepping
// registers hold the address, the floor and the ceiling. Inside a sweep
// the address moves by the stride toward the ceiling; between sweeps the
// floor and ceiling move by their own signed offsets and the address
// restarts at the new floor. Assumes configuration is steady during a run;
// start has priority over hold.
module slide_addr_gen
    import slide_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start_i,
    input  logic          hold_i,
    input  logic [AW-1:0] floor_init_i,
    input  logic [AW-1:0] ceil_init_i,
    input  logic [AW-1:0] stride_i,
    input  logic [AW-1:0] floor_step_i,
    input  logic [AW-1:0] ceil_step_i,
    input  logic [CW-1:0] max_steps_i,
    input  logic [CW-1:0] sweeps_i,
    output logic [AW-1:0] addr_o,
    output logic          valid_o,
    output logic          done_o
);

    localparam int NUM_STEPPERS = 3;
    localparam int IDX_ADDR     = 0;
    localparam int IDX_FLOOR    = 1;
    localparam int IDX_CEIL     = 2;

    logic [AW-1:0] cur_val  [NUM_STEPPERS];
    logic [AW-1:0] ld_val   [NUM_STEPPERS];
    logic [AW-1:0] dlt_val  [NUM_STEPPERS];
    logic          ld_en    [NUM_STEPPERS];
    logic          adv_en   [NUM_STEPPERS];

    logic          up;
    logic          hit;
    logic          emit;
    logic          sweep_end;
    logic          finish;
    logic          slide;
    logic [AW-1:0] next_floor;

    // Three copies of the same stepping register.
    for (genvar g = 0; g < NUM_STEPPERS; g++) begin : g_step
        slide_stepper #(.W(AW)) u_step (
            .clk        (clk),
            .rst_n      (rst_n),
            .load_i     (ld_en[g]),
            .load_val_i (ld_val[g]),
            .adv_i      (adv_en[g]),
            .delta_i    (dlt_val[g]),
            .value_o    (cur_val[g])
        );
    end

    slide_end_detect #(.W(AW)) u_end (
        .addr_i   (cur_val[IDX_ADDR]),
        .floor_i  (cur_val[IDX_FLOOR]),
        .ceil_i   (cur_val[IDX_CEIL]),
        .stride_i (stride_i),
        .up_o     (up),
        .hit_o    (hit)
    );

    slide_seq_ctrl #(.CW(CW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start_i     (start_i),
        .hold_i      (hold_i),
        .hit_i       (hit),
        .max_steps_i (max_steps_i),
        .sweeps_i    (sweeps_i),
        .emit_o      (emit),
        .sweep_end_o (sweep_end),
        .finish_o    (finish),
        .done_o      (done_o)
    );

    // Load, advance and delta selection for each stepping register.
    always_comb begin
        slide      = sweep_end && !finish;
        next_floor = cur_val[IDX_FLOOR] + floor_step_i;

        ld_en[IDX_ADDR]   = start_i || slide;
        ld_val[IDX_ADDR]  = start_i ? floor_init_i : next_floor;
        adv_en[IDX_ADDR]  = emit && !sweep_end;
        dlt_val[IDX_ADDR] = up ? stride_i : ('0 - stride_i);

        ld_en[IDX_FLOOR]   = start_i;
        ld_val[IDX_FLOOR]  = floor_init_i;
        adv_en[IDX_FLOOR]  = slide;
        dlt_val[IDX_FLOOR] = floor_step_i;

        ld_en[IDX_CEIL]   = start_i;
        ld_val[IDX_CEIL]  = ceil_init_i;
        adv_en[IDX_CEIL]  = slide;
        dlt_val[IDX_CEIL] = ceil_step_i;
    end

    assign addr_o  = cur_val[IDX_ADDR];
    assign valid_o = emit;

    // A start always presents the initial floor next cycle, not yet done.
    p_start_load_r2: assert property (@(posedge clk) disable iff (!rst_n)
        start_i |=> (addr_o == $past(floor_init_i)) && !done_o);

    // Every emitted address lies inside the current window.
    p_in_window_r6: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> (up ? (addr_o >= cur_val[IDX_FLOOR] && addr_o <= cur_val[IDX_CEIL])
                        : (addr_o <= cur_val[IDX_FLOOR] && addr_o >= cur_val[IDX_CEIL])));

    // No address is emitted once the run is complete.
    p_no_valid_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
        valid_o |-> !done_o);

    // Hold freezes the address and the completion flag.
    p_hold_freeze_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (hold_i && !start_i) |=> ($stable(addr_o) && $stable(done_o)));

endmodule

// File: tb/slide_addr_gen_tb.sv
// Directed bench for the sliding-window address sequencer.
module slide_addr_gen_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        hold_i = 1'b0;
    logic [15:0] floor_init_i = '0;
    logic [15:0] ceil_init_i = '0;
    logic [15:0] stride_i = '0;
    logic [15:0] floor_step_i = '0;
    logic [15:0] ceil_step_i = '0;
    logic [15:0] max_steps_i = '0;
    logic [15:0] sweeps_i = '0;
    logic [15:0] addr_o;
    logic        valid_o;
    logic        done_o;

    int checks = 0;
    int fails  = 0;

    logic [15:0] exp_q [256];
    int          exp_n;
    logic [15:0] got_q [256];
    int          got_n;

    always #5 clk = ~clk;

    slide_addr_gen u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .hold_i       (hold_i),
        .floor_init_i (floor_init_i),
        .ceil_init_i  (ceil_init_i),
        .stride_i     (stride_i),
        .floor_step_i (floor_step_i),
        .ceil_step_i  (ceil_step_i),
        .max_steps_i  (max_steps_i),
        .sweeps_i     (sweeps_i),
        .addr_o       (addr_o),
        .valid_o      (valid_o),
        .done_o       (done_o)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Expected address list derived from the requirements.
    task automatic model(input logic [15:0] b0, input logic [15:0] c0, input logic [15:0] st,
                         input logic [15:0] bs, input logic [15:0] cs,
                         input logic [15:0] mx, input logic [15:0] sw);
        logic [15:0] b, c, a;
        logic        up, last;
        int          nsw, cap, n;
        nsw = (sw == 0) ? 1 : int'(sw);
        cap = (mx == 0) ? 1 : int'(mx);
        exp_n = 0;
        b = b0;
        c = c0;
        for (int s = 0; s < nsw; s++) begin
            a = b;
            n = 0;
            while (exp_n < 256) begin
                exp_q[exp_n] = a;
                exp_n++;
                n++;
                up   = (b <= c);
                last = up ? ((a >= c) || ((c - a) < st)) : ((a <= c) || ((a - c) < st));
                if (n >= cap) last = 1'b1;
                if (last) break;
                a = up ? (a + st) : (a - st);
            end
            b = b + bs;
            c = c + cs;
        end
    endtask

    task automatic launch(input logic [15:0] b0, input logic [15:0] c0, input logic [15:0] st,
                          input logic [15:0] bs, input logic [15:0] cs,
                          input logic [15:0] mx, input logic [15:0] sw);
        @(negedge clk);
        floor_init_i = b0; ceil_init_i = c0; stride_i = st;
        floor_step_i = bs; ceil_step_i = cs; max_steps_i = mx; sweeps_i = sw;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        model(b0, c0, st, bs, cs, mx, sw);
    endtask

    // Collect emitted addresses until done; optionally hold for 3 cycles.
    task automatic capture(input string req, input int hold_at);
        int guard = 0;
        int hat = hold_at;
        got_n = 0;
        #1;
        while (!done_o && guard < 400) begin
            if (got_n == hat) begin
                hat = -1;
                for (int h = 0; h < 3; h++) begin
                    hold_i = 1'b1;
                    #1;
                    chk("R10", "valid while held", int'(valid_o), 0);
                    chk("R10", "address while held", int'(addr_o), int'(exp_q[got_n]));
                    @(negedge clk);
                end
                hold_i = 1'b0;
                #1;
            end
            if (valid_o && got_n < 256) begin
                got_q[got_n] = addr_o;
                got_n++;
            end
            @(negedge clk);
            #1;
            guard++;
        end
        chk(req, "run completes", int'(guard < 400), 1);
        chk(req, "address count", got_n, exp_n);
        for (int i = 0; i < exp_n && i < got_n; i++)
            chk(req, $sformatf("address %0d", i), int'(got_q[i]), int'(exp_q[i]));
        chk("R9", "valid low at done", int'(valid_o), 0);
    endtask

    task automatic t_reset;
        @(negedge clk); #1;
        chk("R1", "addr after reset", int'(addr_o), 0);
        chk("R1", "valid after reset", int'(valid_o), 0);
        chk("R1", "done after reset", int'(done_o), 0);
    endtask

    task automatic t_first_addr;
        launch(16'd7, 16'd30, 16'd5, 16'd0, 16'd0, 16'd100, 16'd1);
        #1;
        chk("R2", "first valid", int'(valid_o), 1);
        chk("R2", "first address", int'(addr_o), 7);
        chk("R2", "done after start", int'(done_o), 0);
        capture("R3", -1);
    endtask

    task automatic t_exact_ceiling;
        launch(16'd10, 16'd20, 16'd2, 16'd0, 16'd0, 16'd100, 16'd1);
        capture("R5", -1);
        chk("R5", "last is ceiling", int'(got_q[got_n-1]), 20);
    endtask

    task automatic t_overshoot;
        launch(16'd0, 16'd10, 16'd3, 16'd0, 16'd0, 16'd100, 16'd1);
        capture("R6", -1);
        chk("R6", "last below ceiling", int'(got_q[got_n-1]), 9);
        launch(16'hFFF0, 16'hFFFE, 16'd8, 16'd0, 16'd0, 16'd100, 16'd1);
        capture("R6", -1);
    endtask

    task automatic t_down;
        launch(16'd50, 16'd40, 16'd4, 16'd0, 16'd0, 16'd100, 16'd1);
        capture("R4", -1);
    endtask

    task automatic t_cap;
        launch(16'd0, 16'd100, 16'd1, 16'd0, 16'd0, 16'd5, 16'd1);
        capture("R7", -1);
        launch(16'd3, 16'd100, 16'd1, 16'd0, 16'd0, 16'd0, 16'd1);
        capture("R7", -1);
    endtask

    task automatic t_slide;
        launch(16'd0, 16'd6, 16'd2, 16'd3, 16'd3, 16'd100, 16'd3);
        capture("R8", -1);
        launch(16'd100, 16'd90, 16'd5, 16'hFFF6, 16'hFFF6, 16'd100, 16'd2);
        capture("R8", -1);
    endtask

    task automatic t_done_hold;
        launch(16'd1, 16'd4, 16'd1, 16'd0, 16'd0, 16'd100, 16'd0);
        capture("R9", -1);
        repeat (3) @(negedge clk);
        #1;
        chk("R9", "done held", int'(done_o), 1);
        chk("R9", "valid stays low", int'(valid_o), 0);
    endtask

    task automatic t_hold;
        launch(16'd2, 16'd40, 16'd3, 16'd1, 16'd2, 16'd6, 16'd2);
        capture("R10", 3);
    endtask

    task automatic t_restart;
        launch(16'd200, 16'd300, 16'd1, 16'd0, 16'd0, 16'd100, 16'd1);
        @(negedge clk);
        launch(16'd5, 16'd9, 16'd2, 16'd1, 16'd1, 16'd100, 16'd2);
        #1;
        chk("R11", "restart address", int'(addr_o), 5);
        capture("R11", -1);
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_first_addr();
        t_exact_ceiling();
        t_overshoot();
        t_down();
        t_cap();
        t_slide();
        t_done_hold();
        t_hold();
        t_restart();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule